// File: doc/BRIEF.md
# Codec serial host port controller

This block is the device end of a framed synchronous serial link between a host controller and a converter codec. It produces the bit clock from the system clock. Every frame it moves one 16-bit word in each direction: a word for the digital-to-analog path arrives on the serial input, and a word from the analog-to-digital path leaves on the serial output. As frame master it generates the frame-sync pulse itself. As slave it follows a frame-sync pulse from the host. The converter words are exchanged with the rest of the chip through parallel ports.

Two hardware-control inputs are captured on each frame. With both low, the port runs under software control. In that mode, bit 0 of a data word asks for a control frame to follow. In that control frame the host writes one 8-bit configuration register, and the port returns the register addressed by the previous control word. The word occupies either the first or the second 16-bit slot after the frame-sync falling edge.

The sequencer is a state machine with four states. IDLE waits for the first frame after reset. LEAD counts off the unused first slot when the late slot is selected. XFER shifts the word. TAIL waits out the rest of the frame. The transitions are:
- any state → XFER on a frame start with the early slot selected;
- any state → LEAD on a frame start with the late slot selected;
- LEAD → XFER at the rising edge that opens bit period 16;
- XFER → TAIL at the falling edge that samples the 16th bit.

A separate two-value phase register, PRIMARY or SECONDARY, tracks which kind of frame comes next.

Top module: `codec_port`

## Requirements
- R1: `bclk` is a square wave with a period of 2·CLK_HALF clock cycles. With `master_en` high, `fsync_out` falls on a `bclk` rising edge and stays low for exactly one `bclk` period, once every FRAME_LEN (default 32) `bclk` periods. With `master_en` low, `fsync_out` stays high and `fsync_in` is used instead.
- R2: A frame starts at the `bclk` rising edge where the frame sync is sampled low after having been high. The period that edge opens is bit period 0. With `late_slot` at 0 the word uses periods 0 to 15. With `late_slot` at 1 it uses periods 16 to 31.
- R3: `sdo` sends the word MSB first and changes on `bclk` rising edges. `sdo_en` is high from the rising edge that opens the slot until the falling edge that samples the 16th bit, and low at all other times. While `sdo_en` is low, `sdo` is 0.
- R4: `sdi` is sampled MSB first on `bclk` falling edges. When a PRIMARY frame completes, the received word appears on `dac_word` and `dac_valid` is high for exactly one clock cycle.
- R5: In a PRIMARY frame, `adc_word` is taken at the rising edge that opens the slot, and that value is the word sent.
- R6: `hwctl` is captured when the frame sync rises. A captured value of 2'b00 selects software control. Any other value selects hardware control.
- R7: Under software control, a PRIMARY word whose bit 0 is 1 makes the next frame SECONDARY. A bit 0 of 0 keeps the next frame PRIMARY. A SECONDARY frame is always followed by a PRIMARY one. Under hardware control, every frame is PRIMARY whatever bit 0 holds.
- R8: A SECONDARY frame's received word carries a register address in bits 15:9 and register data in bits 8:1. It writes that register if the address is below NREG (default 8). A higher address changes no register. A SECONDARY frame never raises `dac_valid`.
- R9: A SECONDARY frame sends {address of the previous control word, that register's contents, 1'b1}. The contents read as 0 for an address of NREG or above. After reset the remembered address is 0.
- R10: Register 0 holds the oversampling ratio and resets to 160. Register 1 holds the DAC attenuation and resets to 0xFF (fully muted). Register 2 holds the ADC gain and resets to 0x00 (0 dB). Register 3 holds the input selection and resets to 0x00 (differential input, main input pair). Registers 0 to 3 drive `cfg_osr`, `cfg_dac_att`, `cfg_adc_gain` and `cfg_in_sel`. Any other register resets to 0.
- R11: While `rst_n` is low: `sdo_en` and `dac_valid` are low, `fsync_out` is high, software control is selected, and all registers hold their reset values. The first frame after reset is PRIMARY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | 1: port generates frame sync; 0: frame sync comes from `fsync_in` |
| late_slot | input | 1 | 0: word in first 16 bit periods; 1: word in periods 16 to 31 |
| hwctl | input | 2 | Hardware-control pins, captured on frame-sync rise |
| fsync_in | input | 1 | External frame sync (slave), active low |
| sdi | input | 1 | Serial data from host |
| adc_word | input | 16 | Converter result to send in PRIMARY frames |
| bclk | output | 1 | Generated bit clock |
| fsync_out | output | 1 | Generated frame sync (master), active low |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Output-drive enable for `sdo` |
| dac_word | output | 16 | Last received PRIMARY word |
| dac_valid | output | 1 | One-cycle strobe when `dac_word` updates |
| cfg_osr | output | 8 | Register 0: oversampling ratio |
| cfg_dac_att | output | 8 | Register 1: DAC attenuation |
| cfg_adc_gain | output | 8 | Register 2: ADC gain |
| cfg_in_sel | output | 8 | Register 3: input selection |

## Verification
A wrong phase register shows at the ports within the next frame. The port then sends the register readback where the converter word should go, or the reverse, and `dac_valid` fires or stays quiet when it should not. A slip in the bit or slot counters shows within the same frame: `sdo_en` rises or falls in the wrong bit period, or the word on `sdo` is shifted and the word on `dac_word` is misaligned. A wrong captured control mode or register write shows at the next SECONDARY frame: either the expected control frame never happens, or a `cfg_*` output and the readback word differ from the values the host wrote.

// File: rtl/codec_port_pkg.sv
`timescale 1ns/1ps
package codec_port_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 7;
    localparam int REG_W  = 8;

    localparam int A_OSR      = 0;
    localparam int A_DAC_ATT  = 1;
    localparam int A_ADC_GAIN = 2;
    localparam int A_IN_SEL   = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_XFER = 2'd2,
        SQ_TAIL = 2'd3
    } seq_state_t;

    typedef enum logic {
        PH_PRI = 1'b0,
        PH_SEC = 1'b1
    } phase_t;

    function automatic logic [REG_W-1:0] reg_reset(input int idx, input int osr);
        if (idx == A_OSR)
            return REG_W'(osr);
        else if (idx == A_DAC_ATT)
            return {REG_W{1'b1}};
        else
            return '0;
    endfunction

endpackage

// File: rtl/cp_clkgen.sv
`timescale 1ns/1ps
module cp_clkgen #(
    parameter int HALF      = 2,
    parameter int FRAME_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_q,
    output logic rise_p,
    output logic fall_p,
    output logic fs_m,
    output logic fs_m_nxt
);

    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int FCW = $clog2(FRAME_LEN);

    logic [HCW-1:0] hcnt;
    logic [FCW-1:0] fcnt;
    logic [FCW-1:0] fcnt_nxt;
    logic           tick;

    assign tick   = (hcnt == HCW'(HALF - 1));
    assign rise_p = tick & ~sclk_q;
    assign fall_p = tick &  sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            sclk_q <= 1'b0;
        end else begin
            hcnt <= tick ? '0 : hcnt + 1'b1;
            if (tick)
                sclk_q <= ~sclk_q;
        end
    end

    assign fcnt_nxt = (fcnt == FCW'(FRAME_LEN - 1)) ? '0 : fcnt + 1'b1;
    assign fs_m_nxt = (fcnt_nxt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= FCW'(FRAME_LEN - 1);
            fs_m <= 1'b1;
        end else if (rise_p) begin
            fcnt <= fcnt_nxt;
            fs_m <= fs_m_nxt;
        end
    end

    // R1: a generated frame-sync low lasts one bit period only
    a_r1_fs_single_period: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && !fs_m) |=> fs_m);

endmodule

// File: rtl/cp_regfile.sv
`timescale 1ns/1ps
module cp_regfile
    import codec_port_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int OSR_DEFAULT = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [REG_W-1:0]  wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [REG_W-1:0]  rd,
    output logic [REG_W-1:0]  cfg_osr,
    output logic [REG_W-1:0]  cfg_dac_att,
    output logic [REG_W-1:0]  cfg_adc_gain,
    output logic [REG_W-1:0]  cfg_in_sel
);

    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [NREG-1:0][REG_W-1:0] regs;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= reg_reset(g, OSR_DEFAULT);
            else if (we && (wa == ADDR_W'(g)))
                regs[g] <= wd;
        end
    end

    always_comb begin
        if (ra < ADDR_W'(NREG))
            rd = regs[ra[IDXW-1:0]];
        else
            rd = '0;
    end

    assign cfg_osr      = regs[A_OSR];
    assign cfg_dac_att  = regs[A_DAC_ATT];
    assign cfg_adc_gain = regs[A_ADC_GAIN];
    assign cfg_in_sel   = regs[A_IN_SEL];

    // R8: a write beyond the implemented registers leaves every register as it was
    a_r8_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa >= ADDR_W'(NREG))) |=> $stable(regs));

endmodule

// File: rtl/cp_sequencer.sv
`timescale 1ns/1ps
module cp_sequencer
    import codec_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              master_en,
    input  logic              fs_m_nxt,
    input  logic              fsync_in,
    input  logic              late_slot,
    input  logic [1:0]        hwctl,
    input  logic              sdi,
    input  logic [WORD_W-1:0] adc_word,
    input  logic [REG_W-1:0]  rd_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic [WORD_W-1:0] dac_word,
    output logic              dac_valid,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int BPW = $clog2(2 * WORD_W) + 1;
    localparam int CW  = $clog2(WORD_W);
    localparam logic [BPW-1:0] LEAD_LAST = BPW'(WORD_W - 1);
    localparam logic [BPW-1:0] BP_MAX    = {BPW{1'b1}};
    localparam logic [CW-1:0]  BIT_LAST  = CW'(WORD_W - 1);

    seq_state_t state_q, state_d;
    phase_t     phase_q;

    logic              fs_prev;
    logic              fs_cur;
    logic              fs_start;
    logic              fs_rise;
    logic [1:0]        hc_lat;
    logic [BPW-1:0]    bitpos;
    logic [CW-1:0]     rx_cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] tx_word;
    logic              load;
    logic              word_end;
    logic              sw_mode;

    assign fs_cur   = master_en ? fs_m_nxt : fsync_in;
    assign fs_start = rise_p &  fs_prev & ~fs_cur;
    assign fs_rise  = rise_p & ~fs_prev &  fs_cur;
    assign sw_mode  = (hc_lat == 2'b00);
    assign word_in  = {rx_sh[WORD_W-2:0], sdi};
    assign word_end = fall_p && (state_q == SQ_XFER) && (rx_cnt == BIT_LAST);
    assign load     = (fs_start && !late_slot) ||
                      (!fs_start && rise_p && (state_q == SQ_LEAD) && (bitpos == LEAD_LAST));
    assign tx_word  = (phase_q == PH_SEC) ? {rd_addr, rd_data, 1'b1} : adc_word;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (fs_start) begin
            state_d = late_slot ? SQ_LEAD : SQ_XFER;
        end else begin
            unique case (state_q)
                SQ_IDLE: state_d = SQ_IDLE;
                SQ_LEAD: if (rise_p && (bitpos == LEAD_LAST)) state_d = SQ_XFER;
                SQ_XFER: if (word_end) state_d = SQ_TAIL;
                SQ_TAIL: state_d = SQ_TAIL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev   <= 1'b1;
            hc_lat    <= 2'b00;
            bitpos    <= '0;
            rx_cnt    <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sdo_en    <= 1'b0;
            phase_q   <= PH_PRI;
            dac_word  <= '0;
            dac_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            rd_addr   <= '0;
        end else begin
            dac_valid <= 1'b0;
            wr_en     <= 1'b0;
            if (rise_p) begin
                fs_prev <= fs_cur;
                if (fs_rise)
                    hc_lat <= hwctl;
                if (fs_start)
                    bitpos <= '0;
                else if (bitpos != BP_MAX)
                    bitpos <= bitpos + 1'b1;
                if (load) begin
                    tx_sh  <= tx_word;
                    rx_cnt <= '0;
                    sdo_en <= 1'b1;
                end else begin
                    if (fs_start)
                        sdo_en <= 1'b0;
                    if (state_q == SQ_XFER)
                        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
            end
            if (fall_p && (state_q == SQ_XFER)) begin
                rx_sh  <= word_in;
                rx_cnt <= rx_cnt + 1'b1;
                if (rx_cnt == BIT_LAST) begin
                    sdo_en <= 1'b0;
                    if (phase_q == PH_PRI) begin
                        dac_word  <= word_in;
                        dac_valid <= 1'b1;
                        phase_q   <= (sw_mode && word_in[0]) ? PH_SEC : PH_PRI;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= word_in[WORD_W-1 -: ADDR_W];
                        wr_data <= word_in[REG_W:1];
                        rd_addr <= word_in[WORD_W-1 -: ADDR_W];
                        phase_q <= PH_PRI;
                    end
                end
            end
        end
    end

    assign sdo = sdo_en & tx_sh[WORD_W-1];

    // R3: the output is driven only while a word is being shifted
    a_r3_en_only_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> (state_q == SQ_XFER));

    // R4: the received-word strobe lasts a single cycle
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R8: only a primary frame can raise the strobe
    a_r8_no_strobe_secondary: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(phase_q == PH_PRI));

    // R6: the captured control pins change only at a bit-clock rising edge
    a_r6_hc_on_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_p |=> $stable(hc_lat));

    // R8: a register write and a strobe never coincide
    a_r8_write_excl_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !dac_valid);

endmodule

// File: rtl/codec_port.sv
`timescale 1ns/1ps
module codec_port
    import codec_port_pkg::*;
#(
    parameter int CLK_HALF    = 2,
    parameter int FRAME_LEN   = 32,
    parameter int NREG        = 8,
    parameter int OSR_DEFAULT = 160
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        master_en,
    input  logic        late_slot,
    input  logic [1:0]  hwctl,
    input  logic        fsync_in,
    input  logic        sdi,
    input  logic [15:0] adc_word,
    output logic        bclk,
    output logic        fsync_out,
    output logic        sdo,
    output logic        sdo_en,
    output logic [15:0] dac_word,
    output logic        dac_valid,
    output logic [7:0]  cfg_osr,
    output logic [7:0]  cfg_dac_att,
    output logic [7:0]  cfg_adc_gain,
    output logic [7:0]  cfg_in_sel
);

    logic              rise_p;
    logic              fall_p;
    logic              fs_m;
    logic              fs_m_nxt;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [REG_W-1:0]  wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [REG_W-1:0]  rd_data;

    cp_clkgen #(
        .HALF      (CLK_HALF),
        .FRAME_LEN (FRAME_LEN)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_q   (bclk),
        .rise_p   (rise_p),
        .fall_p   (fall_p),
        .fs_m     (fs_m),
        .fs_m_nxt (fs_m_nxt)
    );

    cp_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_p    (rise_p),
        .fall_p    (fall_p),
        .master_en (master_en),
        .fs_m_nxt  (fs_m_nxt),
        .fsync_in  (fsync_in),
        .late_slot (late_slot),
        .hwctl     (hwctl),
        .sdi       (sdi),
        .adc_word  (adc_word),
        .rd_data   (rd_data),
        .sdo       (sdo),
        .sdo_en    (sdo_en),
        .dac_word  (dac_word),
        .dac_valid (dac_valid),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr)
    );

    cp_regfile #(
        .NREG        (NREG),
        .OSR_DEFAULT (OSR_DEFAULT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (wr_en),
        .wa           (wr_addr),
        .wd           (wr_data),
        .ra           (rd_addr),
        .rd           (rd_data),
        .cfg_osr      (cfg_osr),
        .cfg_dac_att  (cfg_dac_att),
        .cfg_adc_gain (cfg_adc_gain),
        .cfg_in_sel   (cfg_in_sel)
    );

    assign fsync_out = master_en ? fs_m : 1'b1;

endmodule

// File: tb/codec_port_bench.sv
`timescale 1ns/1ps
module codec_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic        late_slot = 1'b0;
    logic [1:0]  hwctl = 2'b00;
    logic        fsync_in = 1'b1;
    logic        sdi = 1'b0;
    logic [15:0] adc_word = 16'h0000;
    logic        bclk;
    logic        fsync_out;
    logic        sdo;
    logic        sdo_en;
    logic [15:0] dac_word;
    logic        dac_valid;
    logic [7:0]  cfg_osr;
    logic [7:0]  cfg_dac_att;
    logic [7:0]  cfg_adc_gain;
    logic [7:0]  cfg_in_sel;

    int n_chk  = 0;
    int n_fail = 0;
    int n_stb  = 0;
    logic [15:0] last_dac = 16'h0;

    always #10 clk = ~clk;

    codec_port u_codec_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .late_slot    (late_slot),
        .hwctl        (hwctl),
        .fsync_in     (fsync_in),
        .sdi          (sdi),
        .adc_word     (adc_word),
        .bclk         (bclk),
        .fsync_out    (fsync_out),
        .sdo          (sdo),
        .sdo_en       (sdo_en),
        .dac_word     (dac_word),
        .dac_valid    (dac_valid),
        .cfg_osr      (cfg_osr),
        .cfg_dac_att  (cfg_dac_att),
        .cfg_adc_gain (cfg_adc_gain),
        .cfg_in_sel   (cfg_in_sel)
    );

    always @(negedge clk) begin
        if (dac_valid) begin
            n_stb++;
            last_dac = dac_word;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one host-side frame; returns the word seen on sdo, enable errors and strobes seen
    task automatic do_frame(input logic [15:0] tx, output logic [15:0] rx,
                            output logic oe_bad, output int stb);
        int s0;
        oe_bad = 1'b0;
        rx = 16'h0;
        if (master_en) begin
            do begin
                @(posedge bclk); #1;
            end while (fsync_out !== 1'b0);
        end else begin
            @(posedge bclk); #1;
            fsync_in = 1'b0;
            @(posedge bclk); #1;
            fsync_in = 1'b1;
        end
        s0 = n_stb;
        if (late_slot) begin
            for (int k = 0; k < 16; k++) begin
                if (sdo_en !== 1'b0) oe_bad = 1'b1;
                @(posedge bclk); #1;
            end
        end
        for (int i = 15; i >= 0; i--) begin
            if (sdo_en !== 1'b1) oe_bad = 1'b1;
            rx[i] = sdo;
            sdi = tx[i];
            if (i > 0) begin
                @(posedge bclk); #1;
            end
        end
        @(negedge bclk);
        repeat (2) @(negedge clk);
        if (sdo_en !== 1'b0) oe_bad = 1'b1;
        sdi = 1'b0;
        stb = n_stb - s0;
    endtask

    task automatic t_reset_defaults();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 sdo_en in reset", sdo_en, 1'b0);
        chk("R11 dac_valid in reset", dac_valid, 1'b0);
        chk("R11 fsync_out in reset", fsync_out, 1'b1);
        chk("R10 osr default", cfg_osr, 8'd160);
        chk("R10 dac attenuation default", cfg_dac_att, 8'hFF);
        chk("R10 adc gain default", cfg_adc_gain, 8'h00);
        chk("R10 input select default", cfg_in_sel, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_master_timing();
        int n;
        logic hi_after;
        realtime t0, t1;
        do begin
            @(posedge bclk); #1;
        end while (fsync_out !== 1'b0);
        t0 = $realtime;
        n = 0;
        hi_after = 1'b0;
        do begin
            @(posedge bclk); #1;
            n++;
            if (n == 1) begin
                hi_after = fsync_out;
                t1 = $realtime;
            end
        end while (fsync_out !== 1'b0);
        chk("R1 fsync low one period", hi_after, 1'b1);
        chk("R1 frame period in bclk", n, 32);
        chk("R1 bclk period ns", int'(t1 - t0), 80);
    endtask

    task automatic t_primary_data();
        logic [15:0] rx;
        logic bad;
        int stb;
        adc_word = 16'hA5C3;
        do_frame(16'h1234, rx, bad, stb);
        chk("R3 R5 sdo word", rx, 16'hA5C3);
        chk("R3 sdo_en window", bad, 1'b0);
        chk("R4 one strobe", stb, 1);
        chk("R4 dac_word", last_dac, 16'h1234);
    endtask

    task automatic t_control_frames();
        logic [15:0] rx;
        logic bad;
        int stb;
        adc_word = 16'h0F0F;
        do_frame(16'h5671, rx, bad, stb);
        chk("R7 primary before control", rx, 16'h0F0F);
        adc_word = 16'hDEAD;
        do_frame(16'h0479, rx, bad, stb);
        chk("R9 readback after reset addr0", rx, 16'h0141);
        chk("R8 no strobe in secondary", stb, 0);
        chk("R8 gain written", cfg_adc_gain, 8'h3C);
        adc_word = 16'hBEEF;
        do_frame(16'h1111, rx, bad, stb);
        chk("R7 secondary followed by primary", rx, 16'hBEEF);
        do_frame(16'hC8AB, rx, bad, stb);
        chk("R9 readback addr2", rx, 16'h0479);
        chk("R8 out of range osr", cfg_osr, 8'd160);
        chk("R8 out of range att", cfg_dac_att, 8'hFF);
        chk("R8 out of range gain", cfg_adc_gain, 8'h3C);
        chk("R8 out of range in_sel", cfg_in_sel, 8'h00);
        adc_word = 16'h1357;
        do_frame(16'h2220, rx, bad, stb);
        chk("R7 primary word", rx, 16'h1357);
        adc_word = 16'h2468;
        do_frame(16'h3330, rx, bad, stb);
        chk("R7 lsb 0 keeps primary", rx, 16'h2468);
        chk("R4 strobe after lsb0", stb, 1);
        do_frame(16'h0003, rx, bad, stb);
        do_frame(16'h0221, rx, bad, stb);
        chk("R9 readback out of range is zero", rx, 16'hC801);
        chk("R8 attenuation written", cfg_dac_att, 8'h10);
    endtask

    task automatic t_hw_mode();
        logic [15:0] rx;
        logic bad;
        int stb;
        hwctl = 2'b10;
        adc_word = 16'h0A0A;
        do_frame(16'h4441, rx, bad, stb);
        adc_word = 16'h0B0B;
        do_frame(16'h5551, rx, bad, stb);
        chk("R6 R7 hardware mode stays primary", rx, 16'h0B0B);
        chk("R7 hardware mode strobe", stb, 1);
        chk("R7 hardware mode dac_word", last_dac, 16'h5551);
        chk("R7 hardware mode no write", cfg_adc_gain, 8'h3C);
        hwctl = 2'b00;
        do_frame(16'h0000, rx, bad, stb);
    endtask

    task automatic t_late_slot();
        logic [15:0] rx;
        logic bad;
        int stb;
        late_slot = 1'b1;
        adc_word = 16'h7777;
        do_frame(16'h6660, rx, bad, stb);
        chk("R2 late slot word", rx, 16'h7777);
        chk("R2 R3 late slot enable window", bad, 1'b0);
        chk("R2 late slot dac_word", last_dac, 16'h6660);
        late_slot = 1'b0;
    endtask

    task automatic t_slave();
        logic [15:0] rx;
        logic bad;
        int stb;
        master_en = 1'b0;
        adc_word = 16'h9999;
        do_frame(16'h8880, rx, bad, stb);
        chk("R1 slave fsync_out high", fsync_out, 1'b1);
        chk("R2 slave word", rx, 16'h9999);
        chk("R4 slave dac_word", last_dac, 16'h8880);
        do_frame(16'h8881, rx, bad, stb);
        do_frame(16'h0685, rx, bad, stb);
        chk("R9 slave readback addr1", rx, 16'h0221);
        chk("R8 slave write in_sel", cfg_in_sel, 8'h42);
        master_en = 1'b1;
    endtask

    task automatic t_reset_phase();
        logic [15:0] rx;
        logic bad;
        int stb;
        do_frame(16'h0001, rx, bad, stb);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 R10 in_sel restored", cfg_in_sel, 8'h00);
        chk("R11 R10 gain restored", cfg_adc_gain, 8'h00);
        rst_n = 1'b1;
        adc_word = 16'hCAFE;
        do_frame(16'h0002, rx, bad, stb);
        chk("R11 first frame primary", rx, 16'hCAFE);
        chk("R11 first frame strobe", stb, 1);
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_master_timing();
        t_primary_data();
        t_control_frames();
        t_hw_mode();
        t_late_slot();
        t_slave();
        t_reset_phase();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule